// File: doc/BRIEF.md
# Pipelined Booth Carry-Save Multiplier

This block multiplies two 32-bit two's-complement operands and returns the full 64-bit signed product. The multiplier operand is recoded into radix-4 digits, so 16 partial-product rows are formed instead of 32. A 17th row carries a single sign-correction constant. The rows then pass through a tree of vector-wide 4:2 and 3:2 carry-save compressors. Register banks sit between groups of compressor layers. The two vectors that remain are resolved by a carry-select adder built from fixed-width blocks.

The pipeline has a fixed latency and accepts a new operand pair on every clock cycle. A qualifier bit travels alongside each pair. It is raised at the output in exactly the cycle that carries that pair's result. There is no stall or backpressure: results emerge whether or not anything downstream is ready. A synchronous active-high reset clears every qualifier bit in flight. The data registers are left unreset.

Top module: `booth_csa_mul`

## Requirements
- R1: For every pair accepted with `valid_in` high, `product` equals the low 64 bits of the signed product `a_in` × `b_in`.
- R2: With the default parameters (two compressor layers per register bank), a pair sampled at rising edge k appears on `product` with `valid_out` high after edge k+3. That is four register stages.
- R3: `valid_out` is `valid_in` delayed by exactly the pipeline latency. Back-to-back inputs give back-to-back results, and idle input cycles give idle output cycles in the matching slots.
- R4: A rising edge with `rst` high clears every in-flight qualifier. `valid_out` stays low afterwards until a pair accepted after the reset has crossed the full pipeline.
- R5: Digit i comes from the bit triplet (b[2i+1], b[2i], b[2i-1]), with b[-1] = 0. The triplets decode as follows:
  - 000 and 111 select 0.
  - 001 and 010 select +A.
  - 011 selects +2A.
  - 100 selects -2A.
  - 101 and 110 select -A.

  Results are exact for the extreme operands -2^31, 2^31-1, -1 and 0, and for alternating bit patterns.
- R6: A negated row is formed as the inverted row plus a 1 placed at that row's lowest column. The 1 is carried in a free low column of the next row; the last row's 1 goes into the constant row. Each row stores its sign as a complemented bit, and one constant replaces all sign extension. The 17 rows sum, modulo 2^64, to the product.
- R7: In a 3:2 cell, the sum is the XOR of the three inputs and the carry is their majority, moved one column up. A 4:2 cell preserves the value of its four inputs. Its sideways carry never depends on a neighbour's sideways carry.
- R8: The final adder splits 64 bits into 8-bit blocks. Each block precomputes its result for carry-in 0 and carry-in 1, and the carry out of the block below selects one. The result equals a full 64-bit addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the qualifier pipeline |
| valid_in | input | 1 | Marks `a_in`/`b_in` as a pair to multiply this cycle |
| a_in | input | 32 | Multiplicand, two's complement |
| b_in | input | 32 | Multiplier, two's complement, radix-4 recoded |
| valid_out | output | 1 | Marks `product` as the result of an accepted pair |
| product | output | 64 | Registered signed product |

## Verification
The datapath is purely feed-forward, with no state shared between operand pairs. A wrong Booth decode, a misplaced correction bit or a faulty compressor or adder block therefore corrupts only the pairs that touch it. The wrong value appears on `product` exactly four cycles after the pair is accepted. Directed extreme operands and alternating patterns force every triplet code and long carry chains, and random pairs cover the remaining mix. A fault in the qualifier chain shows up as `valid_out` rising early, late or missing, in the first cycle that the delayed-input model predicts differently, including right after a reset taken mid-stream.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef struct packed {
    logic one;
    logic two;
    logic neg;
  } booth_sel_t;

  function automatic booth_sel_t booth_decode(input logic [2:0] trip);
    booth_sel_t r;
    case (trip)
      3'b001, 3'b010: r = '{one: 1'b1, two: 1'b0, neg: 1'b0};
      3'b011:         r = '{one: 1'b0, two: 1'b1, neg: 1'b0};
      3'b100:         r = '{one: 1'b0, two: 1'b1, neg: 1'b1};
      3'b101, 3'b110: r = '{one: 1'b1, two: 1'b0, neg: 1'b1};
      default:        r = '{one: 1'b0, two: 1'b0, neg: 1'b0};
    endcase
    return r;
  endfunction

  // Rows remaining after one compressor layer: 4:2 groups first, a 3:2 on a leftover triple.
  function automatic int next_rows(input int n);
    return (n / 4) * 2 + (((n % 4) == 3) ? 2 : (n % 4));
  endfunction

  function automatic int rows_after(input int n0, input int l);
    int n;
    n = n0;
    for (int j = 0; j < l; j++) n = next_rows(n);
    return n;
  endfunction

  function automatic int num_levels(input int n0);
    int n;
    int c;
    n = n0;
    c = 0;
    while (n > 2) begin
      n = next_rows(n);
      c++;
    end
    return c;
  endfunction

  function automatic int level_base(input int n0, input int l);
    int s;
    s = 0;
    for (int j = 0; j < l; j++) s += rows_after(n0, j);
    return s;
  endfunction

  function automatic int num_banks(input int nl, input int lps);
    return (nl + lps - 1) / lps;
  endfunction

endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mul_pkg::*;
#(
  parameter int W  = 32,
  parameter int ND = W / 2,
  parameter int NR = ND + 1,
  parameter int PW = 2 * W
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [PW-1:0] rows [NR]
);

  function automatic logic [PW-1:0] sign_fix(input int nd);
    logic [PW-1:0] k;
    k = '0;
    for (int i = 0; i < nd; i++) k = k - (PW'(1) << (W + 2 * i));
    return k;
  endfunction

  localparam logic [PW-1:0] KFIX = sign_fix(ND);

  logic [ND-1:0] neg;

  for (genvar i = 0; i < ND; i++) begin : g_dig
    logic [2:0]  trip;
    booth_sel_t  sel;
    logic [W:0]  mag;
    logic [W:0]  p;
    if (i == 0) begin : g_t0
      assign trip = {b[1], b[0], 1'b0};
    end else begin : g_tn
      assign trip = b[2*i+1 : 2*i-1];
    end
    assign sel    = booth_decode(trip);
    assign mag    = sel.one ? {a[W-1], a} : (sel.two ? {a, 1'b0} : '0);
    assign p      = mag ^ {(W + 1){sel.neg}};
    assign neg[i] = sel.neg;
    if (i == 0) begin : g_r0
      assign rows[0] = PW'({~p[W], p[W-1:0]});
    end else begin : g_rn
      // the previous row's +1 rides in this row's free low columns
      assign rows[i] = (PW'({~p[W], p[W-1:0]}) << (2 * i))
                     | (PW'(neg[i-1]) << (2 * i - 2));
    end
  end

  assign rows[ND] = KFIX | (PW'(neg[ND-1]) << (W - 2));

  always_comb begin
    logic [PW-1:0] acc;
    logic [PW-1:0] ref_p;
    acc = '0;
    for (int k = 0; k < NR; k++) acc = acc + rows[k];
    ref_p = PW'({{W{a[W-1]}}, a}) * PW'({{W{b[W-1]}}, b});
    if (!$isunknown({a, b}))
      assert_rows_sum_R6: assert (acc == ref_p)
        else $error("partial rows do not sum to the product");
  end

endmodule

// File: rtl/csa_3to2.sv
module csa_3to2 #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  logic [W-1:0] m;

  always_comb begin
    s  = a ^ b ^ c;
    m  = (a & b) | (a & c) | (b & c);
    cy = {m[W-2:0], 1'b0};
  end

  always_comb begin
    if (!$isunknown({a, b, c}))
      assert_csa32_R7: assert (({2'b0, a} + {2'b0, b} + {2'b0, c}) == ({2'b0, s} + {1'b0, m, 1'b0}))
        else $error("3:2 cell loses value");
  end

endmodule

// File: rtl/csa_4to2.sv
module csa_4to2 #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);

  logic [W-1:0] t;
  logic [W-1:0] side;
  logic [W-1:0] cin;
  logic [W-1:0] k;

  always_comb begin
    t    = a ^ b ^ c;
    side = (a & b) | (a & c) | (b & c);   // depends on a, b, c only: no lateral chain
    cin  = {side[W-2:0], 1'b0};
    s    = t ^ d ^ cin;
    k    = (t & d) | (t & cin) | (d & cin);
    cy   = {k[W-2:0], 1'b0};
  end

  always_comb begin
    if (!$isunknown({a, b, c, d}))
      assert_csa42_R7: assert (({3'b0, a} + {3'b0, b} + {3'b0, c} + {3'b0, d})
                               == ({3'b0, s} + {2'b0, k, 1'b0} + {2'b0, side[W-1], {W{1'b0}}}))
        else $error("4:2 cell loses value");
  end

endmodule

// File: rtl/csa_tree.sv
module csa_tree
  import booth_mul_pkg::*;
#(
  parameter int PW  = 64,
  parameter int NR  = 17,
  parameter int LPS = 2
) (
  input  logic          clk,
  input  logic [PW-1:0] rows [NR],
  output logic [PW-1:0] vs,
  output logic [PW-1:0] vc
);

  localparam int NL  = num_levels(NR);
  localparam int TOT = level_base(NR, NL + 1);

  logic [PW-1:0] node [TOT];

  for (genvar k = 0; k < NR; k++) begin : g_in
    assign node[k] = rows[k];
  end

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int NI = rows_after(NR, l);
    localparam int NO = rows_after(NR, l + 1);
    localparam int IB = level_base(NR, l);
    localparam int OB = level_base(NR, l + 1);
    localparam int NG = NI / 4;
    localparam int RM = NI % 4;
    localparam bit DOREG = (((l + 1) % LPS) == 0) || (l == NL - 1);

    logic [PW-1:0] nxt [NO];

    for (genvar g = 0; g < NG; g++) begin : g_c42
      csa_4to2 #(.W(PW)) u_c42 (
        .a (node[IB + 4*g]),
        .b (node[IB + 4*g + 1]),
        .c (node[IB + 4*g + 2]),
        .d (node[IB + 4*g + 3]),
        .s (nxt[2*g]),
        .cy(nxt[2*g + 1])
      );
    end

    if (RM == 3) begin : g_c32
      csa_3to2 #(.W(PW)) u_c32 (
        .a (node[IB + 4*NG]),
        .b (node[IB + 4*NG + 1]),
        .c (node[IB + 4*NG + 2]),
        .s (nxt[2*NG]),
        .cy(nxt[2*NG + 1])
      );
    end else begin : g_pass
      for (genvar r = 0; r < RM; r++) begin : g_p
        assign nxt[2*NG + r] = node[IB + 4*NG + r];
      end
    end

    if (DOREG) begin : g_reg
      logic [PW-1:0] q [NO];
      always_ff @(posedge clk) begin
        for (int k = 0; k < NO; k++) q[k] <= nxt[k];
      end
      for (genvar k = 0; k < NO; k++) begin : g_o
        assign node[OB + k] = q[k];
      end
    end else begin : g_wire
      for (genvar k = 0; k < NO; k++) begin : g_o
        assign node[OB + k] = nxt[k];
      end
    end
  end

  assign vs = node[level_base(NR, NL)];
  assign vc = node[level_base(NR, NL) + 1];

endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
  parameter int W   = 64,
  parameter int BLK = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  localparam int NB = W / BLK;

  logic [NB:0] cc;

  assign cc[0] = 1'b0;

  for (genvar g = 0; g < NB; g++) begin : g_blk
    logic [BLK:0] s0;
    logic [BLK:0] s1;
    assign s0 = {1'b0, x[g*BLK +: BLK]} + {1'b0, y[g*BLK +: BLK]};
    assign s1 = {1'b0, x[g*BLK +: BLK]} + {1'b0, y[g*BLK +: BLK]} + {{BLK{1'b0}}, 1'b1};
    assign s[g*BLK +: BLK] = cc[g] ? s1[BLK-1:0] : s0[BLK-1:0];
    assign cc[g+1]         = cc[g] ? s1[BLK] : s0[BLK];
  end

  always_comb begin
    if (!$isunknown({x, y}))
      assert_csel_R8: assert ({cc[NB], s} == ({1'b0, x} + {1'b0, y}))
        else $error("carry-select sum differs from full add");
  end

endmodule

// File: rtl/booth_csa_mul.sv
module booth_csa_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH            = 32,
  parameter int LAYERS_PER_STAGE = 2,
  parameter int ADD_BLOCK        = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic [WIDTH-1:0]     a_in,
  input  logic [WIDTH-1:0]     b_in,
  output logic                 valid_out,
  output logic [2*WIDTH-1:0]   product
);

  localparam int PW      = 2 * WIDTH;
  localparam int ND      = WIDTH / 2;
  localparam int NR      = ND + 1;
  localparam int NL      = num_levels(NR);
  localparam int LATENCY = 2 + num_banks(NL, LAYERS_PER_STAGE);
  localparam int SW      = $clog2(LATENCY + 1);

  logic [WIDTH-1:0]   a_q;
  logic [WIDTH-1:0]   b_q;
  logic [PW-1:0]      rows [NR];
  logic [PW-1:0]      vs;
  logic [PW-1:0]      vc;
  logic [PW-1:0]      sum;
  logic [LATENCY-1:0] vld;

  always_ff @(posedge clk) begin
    a_q <= a_in;
    b_q <= b_in;
  end

  booth_pp_gen #(.W(WIDTH), .ND(ND), .NR(NR), .PW(PW)) u_pp (
    .a   (a_q),
    .b   (b_q),
    .rows(rows)
  );

  csa_tree #(.PW(PW), .NR(NR), .LPS(LAYERS_PER_STAGE)) u_tree (
    .clk (clk),
    .rows(rows),
    .vs  (vs),
    .vc  (vc)
  );

  csel_adder #(.W(PW), .BLK(ADD_BLOCK)) u_add (
    .x(vs),
    .y(vc),
    .s(sum)
  );

  always_ff @(posedge clk) begin
    product <= sum;
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LATENCY-2:0], valid_in};
  end

  assign valid_out = vld[LATENCY-1];

  logic [SW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                           since_rst <= '0;
    else if (since_rst != SW'(LATENCY)) since_rst <= since_rst + 1'b1;
  end

  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == SW'(LATENCY)) |-> (valid_out == $past(valid_in, LATENCY)))
    else $error("valid_out is not valid_in delayed by the latency");

endmodule

// File: tb/booth_csa_mul_test.sv
`timescale 1ns/1ps
module booth_csa_mul_test;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [31:0] a_in = '0;
  logic [31:0] b_in = '0;
  logic        valid_out;
  logic [63:0] product;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic        qv [LAT];
  logic [63:0] qp [LAT];
  string       qt [LAT];

  always #10 clk = ~clk;

  booth_csa_mul uut (
    .clk      (clk),
    .rst      (rst),
    .valid_in (valid_in),
    .a_in     (a_in),
    .b_in     (b_in),
    .valid_out(valid_out),
    .product  (product)
  );

  function automatic logic [63:0] smul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea;
    logic [63:0] eb;
    ea = {{32{a[31]}}, a};
    eb = {{32{b[31]}}, b};
    return ea * eb;
  endfunction

  task automatic cyc(input logic v, input logic [31:0] a, input logic [31:0] b,
                     input logic r, input string tag);
    valid_in = v;
    a_in     = a;
    b_in     = b;
    rst      = r;
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < LAT; k++) begin
        qv[k] = 1'b0;
        qt[k] = "R4";
      end
    end else begin
      for (int k = LAT - 1; k > 0; k--) begin
        qv[k] = qv[k-1];
        qp[k] = qp[k-1];
        qt[k] = qt[k-1];
      end
      qv[0] = v;
      qp[0] = smul(a, b);
      qt[0] = tag;
    end
    @(negedge clk);
    total++;
    if (valid_out !== qv[LAT-1]) begin
      bad++;
      $display("FAIL %s R3: valid_out=%0b expected %0b", qt[LAT-1], valid_out, qv[LAT-1]);
    end
    if (qv[LAT-1]) begin
      total++;
      if (product !== qp[LAT-1]) begin
        bad++;
        $display("FAIL %s: product=%h expected %h", qt[LAT-1], product, qp[LAT-1]);
      end
    end
  endtask

  function automatic logic [31:0] pick(input int unsigned r);
    case (r % 8)
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      4: return 32'h0000_0001;
      5: return 32'hAAAA_AAAA;
      6: return 32'hCCCC_CCCC;
      default: return 32'h5555_5555;
    endcase
  endfunction

  initial begin
    logic [31:0] ca [12];
    logic [31:0] cb [12];
    void'($urandom(32'd20240611));
    for (int k = 0; k < LAT; k++) begin
      qv[k] = 1'b0;
      qp[k] = '0;
      qt[k] = "R4";
    end

    // R4: reset holds valid_out low
    for (int i = 0; i < 3; i++) cyc(1'b1, 32'd5, 32'd7, 1'b1, "R4");

    // R5 R6: extreme operands and patterns hitting every triplet code
    ca = '{32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001,
           32'hAAAA_AAAA, 32'h1234_5678, 32'h7FFF_FFFF, 32'hCCCC_CCCC, 32'h8000_0000, 32'hFFFF_FFFF};
    cb = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000,
           32'h5555_5555, 32'hFFFF_FFFF, 32'hCCCC_CCCC, 32'h3333_3333, 32'h0000_0001, 32'hAAAA_AAAA};
    for (int i = 0; i < 12; i++) cyc(1'b1, ca[i], cb[i], 1'b0, "R5 R6");

    // R2: isolated pulse, result exactly four edges later
    for (int i = 0; i < 6; i++) cyc(1'b0, '0, '0, 1'b0, "R2");
    cyc(1'b1, 32'hFFFF_FFFE, 32'h0000_0003, 1'b0, "R2");
    for (int i = 0; i < 6; i++) cyc(1'b0, 32'h1111_1111, 32'h2222_2222, 1'b0, "R2");

    // R1 R3 R7 R8: random stream with gaps, some operands from the corner set
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra;
      logic [31:0] rb;
      ra = (($urandom % 5) == 0) ? pick($urandom) : $urandom;
      rb = (($urandom % 5) == 0) ? pick($urandom) : $urandom;
      cyc((($urandom % 4) != 0), ra, rb, 1'b0, "R1 R3 R7 R8");
    end

    // R4: reset while results are in flight
    for (int i = 0; i < 3; i++) cyc(1'b1, $urandom, $urandom, 1'b0, "R4");
    cyc(1'b1, 32'd9, 32'd9, 1'b1, "R4");
    for (int i = 0; i < LAT + 1; i++) cyc(1'b0, '0, '0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) cyc(1'b1, $urandom, $urandom, 1'b0, "R4");
    for (int i = 0; i < LAT + 1; i++) cyc(1'b0, '0, '0, 1'b0, "R3");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule